// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block sits on the device side of a host link. It gives the host a small register window for handing requests to the device and for collecting completions. Two queue ports carry the queued traffic. Reading the inbound port hands the host the offset of a free request slot in device memory. Writing the inbound port posts a filled request, and the device logic then drains it through a simple pop interface. The device pushes completion tokens into an outbound queue. The host collects them by reading the outbound port, and it hands device-memory slots back by writing their offsets to that same port.

Commands outside the queues use a pair of inbound message registers. The device reports that such a command has finished by writing the same value into an outbound message register. A doorbell register, two status/mask pairs and two interrupt lines, one towards each side, complete the block. A request held in host memory is posted as a token with bit 31 set and the 32-byte-aligned bus address shifted right by five in the low bits. A token with bit 31 clear is a device-memory slot offset.

Top module: `qpmu_top`

## Requirements
- R1: After reset both mask registers (0x28 inbound, 0x34 outbound) read 0xF, both interrupt outputs are low and the posted-request queue is empty. The free list holds NUM_SLOTS offsets SLOT_BASE + 32*i, handed out in increasing i.
- R2: A host read of 0x40 returns the oldest free-slot offset on host_rdata_o one cycle after the request and removes it from the free list. With the free list empty it returns 0xFFFFFFFF and removes nothing.
- R3: A host write to 0x40 appends the value to the posted-request queue. The device sees the oldest entry on dev_req_token_o while dev_req_avail_o is high and removes it with dev_req_pop_i. A write to a full queue is dropped.
- R4: A completion pushed by the device is appended to the outbound queue as its token. When the token has bit 31 set and dev_cpl_ctx_en_i is high, dev_cpl_ctx_i is appended instead.
- R5: A host read of 0x44 returns the oldest completion one cycle later and removes it. With the outbound queue empty it returns 0xFFFFFFFF and changes nothing.
- R6: A host write to 0x44 with bit 31 clear returns the value to the tail of the free list. A write with bit 31 set is ignored, and so is a write while the free list is full.
- R7: A host write to 0x10 or 0x14 updates dev_imsg0_o or dev_imsg1_o and sets inbound status bit 0 or 1. The device clears these bits with dev_in_ack_i. A device write through dev_omsg_we_i[0] or [1] updates the outbound message register at 0x18 or 0x1C and sets outbound status bit 0 or 1.
- R8: Outbound status (0x30) has sticky bits 0 and 1, which a host write of one clears, and bit 3, which is high while the outbound queue holds an entry. host_irq_o is high while any status bit is set whose bit in the 0x34 mask is clear.
- R9: A host write to 0x20 ORs the value into the doorbell register, which drives dev_doorbell_o. dev_db_clr_i clears the bits it names. Inbound status (0x24) bit 2 is high while the doorbell is non-zero and bit 3 is high while the posted queue is not empty. Host writes to 0x24 have no effect. dev_in_irq_o is high while any inbound status bit is set whose bit in the 0x28 mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| host_req_i | input | 1 | host access strobe, one access per cycle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | byte offset of the register |
| host_wdata_i | input | 32 | write data |
| host_rdata_o | output | 32 | read data, registered, valid the cycle after a read |
| host_irq_o | output | 1 | interrupt towards the host |
| dev_req_avail_o | output | 1 | posted-request queue not empty |
| dev_req_token_o | output | 32 | oldest posted request token |
| dev_req_pop_i | input | 1 | removes the oldest posted token |
| dev_cpl_push_i | input | 1 | appends a completion |
| dev_cpl_token_i | input | 32 | completion token |
| dev_cpl_ctx_en_i | input | 1 | request carries an output context |
| dev_cpl_ctx_i | input | 32 | low word of the context |
| dev_cpl_full_o | output | 1 | outbound queue full |
| dev_imsg0_o | output | 32 | inbound message 0 |
| dev_imsg1_o | output | 32 | inbound message 1 |
| dev_omsg_we_i | input | 2 | write strobes for outbound messages 0 and 1 |
| dev_omsg_data_i | input | 32 | outbound message write data |
| dev_doorbell_o | output | 32 | doorbell bits |
| dev_db_clr_i | input | 32 | doorbell bits to clear |
| dev_in_ack_i | input | 2 | clears inbound status bits 0 and 1 |
| dev_in_irq_o | output | 1 | interrupt towards the device |

## Verification
Every host write, device push, pop or clear acts on the clock edge where it is sampled. Queue levels, status bits, interrupt lines and the device-facing outputs therefore show the result on the falling edge that follows. Read data comes from a register loaded on the same edge that removes a queue entry, so it is also valid on that falling edge and holds until the next read. The bench drives every stimulus at a falling edge, leaves it on for one full cycle, and samples at the next falling edge. Each check therefore lands exactly one edge after its cause.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned STAT_W     = 4;
  localparam int unsigned SLOT_BYTES = 32;
  localparam int unsigned HOST_TAG   = 31;

  // host-visible offsets; the host software decodes these
  typedef enum logic [7:0] {
    OFF_IMSG0 = 8'h10,
    OFF_IMSG1 = 8'h14,
    OFF_OMSG0 = 8'h18,
    OFF_OMSG1 = 8'h1C,
    OFF_DBELL = 8'h20,
    OFF_ISTAT = 8'h24,
    OFF_IMASK = 8'h28,
    OFF_OSTAT = 8'h30,
    OFF_OMASK = 8'h34,
    OFF_INQ   = 8'h40,
    OFF_OUTQ  = 8'h44
  } reg_off_e;

  localparam int unsigned ST_MSG0 = 0;
  localparam int unsigned ST_MSG1 = 1;
  localparam int unsigned ST_DB   = 2;
  localparam int unsigned ST_Q    = 3;
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
  parameter int unsigned W       = 32,
  parameter int unsigned DEPTH   = 8,
  parameter bit          PRELOAD = 1'b0,
  parameter logic [W-1:0] BASE   = '0,
  parameter logic [W-1:0] STRIDE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
        mem_q[i] <= PRELOAD ? (BASE + W'(i) * STRIDE) : '0;
      end
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= PRELOAD ? CW'(DEPTH) : '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q        <= nxt(wr_ptr_q);
      end
      if (do_pop) rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/qpmu_irq_ctl.sv
module qpmu_irq_ctl #(
  parameter int unsigned   N      = 4,
  parameter logic [N-1:0]  STICKY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] level_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;
  logic         unused_in;

  assign unused_in = ^{set_i, clr_i, level_i};

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign status_o[i] = bit_q;

      p_w1c_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[i] && !set_i[i] |=> !status_o[i]);
      p_set_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> status_o[i]);
    end else begin : g_level
      assign status_o[i] = level_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_o & ~mask_q);
endmodule

// File: rtl/qpmu_top.sv
module qpmu_top
  import qpmu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned POST_DEPTH = 8,
  parameter int unsigned CPL_DEPTH = 8,
  parameter logic [31:0] SLOT_BASE = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic              host_irq_o,
  output logic              dev_req_avail_o,
  output logic [31:0]       dev_req_token_o,
  input  logic              dev_req_pop_i,
  input  logic              dev_cpl_push_i,
  input  logic [31:0]       dev_cpl_token_i,
  input  logic              dev_cpl_ctx_en_i,
  input  logic [31:0]       dev_cpl_ctx_i,
  output logic              dev_cpl_full_o,
  output logic [31:0]       dev_imsg0_o,
  output logic [31:0]       dev_imsg1_o,
  input  logic [1:0]        dev_omsg_we_i,
  input  logic [31:0]       dev_omsg_data_i,
  output logic [31:0]       dev_doorbell_o,
  input  logic [31:0]       dev_db_clr_i,
  input  logic [1:0]        dev_in_ack_i,
  output logic              dev_in_irq_o
);
  localparam logic [DW-1:0] EMPTY_RD = '1;
  localparam logic [DW-1:0] STRIDE   = DW'(SLOT_BYTES);

  logic [DW-1:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q, rdata_q;
  logic rd, wr;
  logic wr_imsg0, wr_imsg1, wr_dbell, wr_imask, wr_ostat, wr_omask, wr_inq, wr_outq;
  logic rd_inq, rd_outq;
  logic [DW-1:0] free_head, post_head, cpl_head, cpl_data;
  logic free_empty, free_full, post_empty, post_full, cpl_empty, cpl_full;
  logic [STAT_W-1:0] istat, imask, ostat, omask;
  logic [STAT_W-1:0] iset, iclr, ilvl, oset, oclr, olvl;
  logic unused_ok;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_off_e off);
    return a == ADDR_W'(off);
  endfunction

  assign rd = host_req_i && !host_we_i;
  assign wr = host_req_i && host_we_i;

  assign wr_imsg0 = wr && hit(host_addr_i, OFF_IMSG0);
  assign wr_imsg1 = wr && hit(host_addr_i, OFF_IMSG1);
  assign wr_dbell = wr && hit(host_addr_i, OFF_DBELL);
  assign wr_imask = wr && hit(host_addr_i, OFF_IMASK);
  assign wr_ostat = wr && hit(host_addr_i, OFF_OSTAT);
  assign wr_omask = wr && hit(host_addr_i, OFF_OMASK);
  assign wr_inq   = wr && hit(host_addr_i, OFF_INQ);
  assign wr_outq  = wr && hit(host_addr_i, OFF_OUTQ);
  assign rd_inq   = rd && hit(host_addr_i, OFF_INQ);
  assign rd_outq  = rd && hit(host_addr_i, OFF_OUTQ);

  // free-slot list, preloaded with aligned device-memory offsets
  qpmu_fifo #(
    .W(DW), .DEPTH(NUM_SLOTS), .PRELOAD(1'b1), .BASE(SLOT_BASE), .STRIDE(STRIDE)
  ) u_free (
    .clk_i, .rst_ni,
    .push_i (wr_outq && !host_wdata_i[HOST_TAG]),
    .data_i (host_wdata_i),
    .pop_i  (rd_inq),
    .data_o (free_head),
    .empty_o(free_empty),
    .full_o (free_full)
  );

  qpmu_fifo #(
    .W(DW), .DEPTH(POST_DEPTH), .PRELOAD(1'b0), .BASE('0), .STRIDE('0)
  ) u_post (
    .clk_i, .rst_ni,
    .push_i (wr_inq),
    .data_i (host_wdata_i),
    .pop_i  (dev_req_pop_i),
    .data_o (post_head),
    .empty_o(post_empty),
    .full_o (post_full)
  );

  assign cpl_data = (dev_cpl_ctx_en_i && dev_cpl_token_i[HOST_TAG]) ? dev_cpl_ctx_i
                                                                     : dev_cpl_token_i;

  qpmu_fifo #(
    .W(DW), .DEPTH(CPL_DEPTH), .PRELOAD(1'b0), .BASE('0), .STRIDE('0)
  ) u_cpl (
    .clk_i, .rst_ni,
    .push_i (dev_cpl_push_i),
    .data_i (cpl_data),
    .pop_i  (rd_outq),
    .data_o (cpl_head),
    .empty_o(cpl_empty),
    .full_o (cpl_full)
  );

  always_comb begin
    iset = '0;
    iset[ST_MSG0] = wr_imsg0;
    iset[ST_MSG1] = wr_imsg1;
    iclr = '0;
    iclr[ST_MSG0] = dev_in_ack_i[0];
    iclr[ST_MSG1] = dev_in_ack_i[1];
    ilvl = '0;
    ilvl[ST_DB] = |dbell_q;
    ilvl[ST_Q]  = !post_empty;
    oset = '0;
    oset[ST_MSG0] = dev_omsg_we_i[0];
    oset[ST_MSG1] = dev_omsg_we_i[1];
    oclr = wr_ostat ? host_wdata_i[STAT_W-1:0] : '0;
    olvl = '0;
    olvl[ST_Q] = !cpl_empty;
  end

  qpmu_irq_ctl #(.N(STAT_W), .STICKY(STAT_W'(3))) u_in_irq (
    .clk_i, .rst_ni,
    .set_i    (iset),
    .clr_i    (iclr),
    .level_i  (ilvl),
    .mask_we_i(wr_imask),
    .mask_d_i (host_wdata_i[STAT_W-1:0]),
    .status_o (istat),
    .mask_o   (imask),
    .irq_o    (dev_in_irq_o)
  );

  qpmu_irq_ctl #(.N(STAT_W), .STICKY(STAT_W'(3))) u_out_irq (
    .clk_i, .rst_ni,
    .set_i    (oset),
    .clr_i    (oclr),
    .level_i  (olvl),
    .mask_we_i(wr_omask),
    .mask_d_i (host_wdata_i[STAT_W-1:0]),
    .status_o (ostat),
    .mask_o   (omask),
    .irq_o    (host_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imsg0_q <= '0;
      imsg1_q <= '0;
      omsg0_q <= '0;
      omsg1_q <= '0;
      dbell_q <= '0;
    end else begin
      if (wr_imsg0)         imsg0_q <= host_wdata_i;
      if (wr_imsg1)         imsg1_q <= host_wdata_i;
      if (dev_omsg_we_i[0]) omsg0_q <= dev_omsg_data_i;
      if (dev_omsg_we_i[1]) omsg1_q <= dev_omsg_data_i;
      // host set wins over a same-cycle device clear
      dbell_q <= (dbell_q & ~dev_db_clr_i) | (wr_dbell ? host_wdata_i : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (host_addr_i)
        ADDR_W'(OFF_IMSG0): rdata_q <= imsg0_q;
        ADDR_W'(OFF_IMSG1): rdata_q <= imsg1_q;
        ADDR_W'(OFF_OMSG0): rdata_q <= omsg0_q;
        ADDR_W'(OFF_OMSG1): rdata_q <= omsg1_q;
        ADDR_W'(OFF_DBELL): rdata_q <= dbell_q;
        ADDR_W'(OFF_ISTAT): rdata_q <= DW'(istat);
        ADDR_W'(OFF_IMASK): rdata_q <= DW'(imask);
        ADDR_W'(OFF_OSTAT): rdata_q <= DW'(ostat);
        ADDR_W'(OFF_OMASK): rdata_q <= DW'(omask);
        ADDR_W'(OFF_INQ):   rdata_q <= free_empty ? EMPTY_RD : free_head;
        ADDR_W'(OFF_OUTQ):  rdata_q <= cpl_empty ? EMPTY_RD : cpl_head;
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata_o    = rdata_q;
  assign dev_req_avail_o = !post_empty;
  assign dev_req_token_o = post_head;
  assign dev_cpl_full_o  = cpl_full;
  assign dev_imsg0_o     = imsg0_q;
  assign dev_imsg1_o     = imsg1_q;
  assign dev_doorbell_o  = dbell_q;
  assign unused_ok       = ^{free_full, post_full};

  p_free_empty_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_inq && free_empty |=> host_rdata_o == EMPTY_RD);
  p_cpl_empty_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_outq && cpl_empty |=> host_rdata_o == EMPTY_RD);
  p_ctx_swap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_cpl_push_i && dev_cpl_ctx_en_i && dev_cpl_token_i[HOST_TAG] && cpl_empty
    |=> cpl_head == $past(dev_cpl_ctx_i));
  p_tagged_free_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_outq && host_wdata_i[HOST_TAG] |=> $stable(free_empty) && $stable(free_head));
  p_queue_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpl_empty && !omask[ST_Q] |-> host_irq_o);
  p_echo_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_omsg_we_i[0] |=> omsg0_q == $past(dev_omsg_data_i));
  p_post_avail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inq && !dev_req_pop_i |=> dev_req_avail_o);
endmodule

// File: tb/qpmu_top_tb_top.sv
`timescale 1ns/1ps
module qpmu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 0, host_we = 0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        req_avail;
  logic [31:0] req_token;
  logic        req_pop = 0;
  logic        cpl_push = 0, ctx_en = 0;
  logic [31:0] cpl_token = '0, cpl_ctx = '0;
  logic        cpl_full;
  logic [31:0] imsg0, imsg1, dbell;
  logic [1:0]  omsg_we = '0;
  logic [31:0] omsg_data = '0, db_clr = '0;
  logic [1:0]  in_ack = '0;
  logic        in_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qpmu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .host_irq_o(host_irq),
    .dev_req_avail_o(req_avail), .dev_req_token_o(req_token), .dev_req_pop_i(req_pop),
    .dev_cpl_push_i(cpl_push), .dev_cpl_token_i(cpl_token),
    .dev_cpl_ctx_en_i(ctx_en), .dev_cpl_ctx_i(cpl_ctx), .dev_cpl_full_o(cpl_full),
    .dev_imsg0_o(imsg0), .dev_imsg1_o(imsg1),
    .dev_omsg_we_i(omsg_we), .dev_omsg_data_i(omsg_data),
    .dev_doorbell_o(dbell), .dev_db_clr_i(db_clr),
    .dev_in_ack_i(in_ack), .dev_in_irq_o(in_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_req = 0;
    d = host_rdata;
  endtask

  task automatic dev_push(input logic [31:0] tok, input logic en, input logic [31:0] ctx);
    @(negedge clk);
    cpl_push = 1; cpl_token = tok; ctx_en = en; cpl_ctx = ctx;
    @(negedge clk);
    cpl_push = 0; ctx_en = 0;
  endtask

  task automatic dev_pop();
    @(negedge clk);
    req_pop = 1;
    @(negedge clk);
    req_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    host_rd(8'h28, d); check("R1 inbound mask", d, 32'hF);
    host_rd(8'h34, d); check("R1 outbound mask", d, 32'hF);
    check("R1 host irq", 32'(host_irq), 0);
    check("R1 dev irq", 32'(in_irq), 0);
    check("R1 posted empty", 32'(req_avail), 0);
  endtask

  task automatic t_free_list();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      host_rd(8'h40, d);
      check("R1 R2 slot order", d, 32'h1000 + 32'(i) * 32);
    end
    host_rd(8'h40, d); check("R2 empty free list", d, 32'hFFFF_FFFF);
    host_wr(8'h44, 32'h1040);
    host_wr(8'h44, 32'h8000_0040);
    host_rd(8'h40, d); check("R6 freed slot", d, 32'h1040);
    host_rd(8'h40, d); check("R6 tagged write ignored", d, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) host_wr(8'h44, 32'h2000 + 32'(i) * 32);
    host_wr(8'h44, 32'h3000);
    for (int i = 0; i < 8; i++) begin
      host_rd(8'h40, d);
      check("R6 refill order", d, 32'h2000 + 32'(i) * 32);
    end
    host_rd(8'h40, d); check("R6 write to full list ignored", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_post();
    logic [31:0] d;
    host_wr(8'h40, 32'h8000_0123);
    host_wr(8'h40, 32'h0000_1020);
    check("R3 avail", 32'(req_avail), 1);
    check("R3 first token", req_token, 32'h8000_0123);
    host_rd(8'h24, d); check("R9 istat queue bit", d, 32'h8);
    dev_pop();
    check("R3 second token", req_token, 32'h0000_1020);
    dev_pop();
    check("R3 drained", 32'(req_avail), 0);
    for (int i = 0; i < 9; i++) host_wr(8'h40, 32'h100 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      check("R3 fill order", req_token, 32'h100 + 32'(i));
      dev_pop();
    end
    check("R3 write to full queue dropped", 32'(req_avail), 0);
  endtask

  task automatic t_cpl();
    logic [31:0] d;
    host_wr(8'h34, 32'h0);
    check("R8 irq low when empty", 32'(host_irq), 0);
    dev_push(32'h0000_1020, 1'b0, 32'h0);
    check("R8 irq on completion", 32'(host_irq), 1);
    dev_push(32'h8000_0123, 1'b1, 32'h1234_5678);
    dev_push(32'h8000_0200, 1'b0, 32'hDEAD_BEEF);
    dev_push(32'h0000_1040, 1'b1, 32'hDEAD_BEEF);
    host_rd(8'h30, d); check("R8 ostat queue bit", d, 32'h8);
    host_wr(8'h34, 32'h8);
    check("R8 masked queue irq", 32'(host_irq), 0);
    host_wr(8'h34, 32'h0);
    host_rd(8'h44, d); check("R5 plain token", d, 32'h0000_1020);
    host_rd(8'h44, d); check("R4 context replaces token", d, 32'h1234_5678);
    host_rd(8'h44, d); check("R4 tagged without context", d, 32'h8000_0200);
    check("R8 irq while entries left", 32'(host_irq), 1);
    host_rd(8'h44, d); check("R4 untagged keeps token", d, 32'h0000_1040);
    check("R8 irq drops when empty", 32'(host_irq), 0);
    host_rd(8'h44, d); check("R5 empty outbound", d, 32'hFFFF_FFFF);
    check("R5 still empty", 32'(host_irq), 0);
  endtask

  task automatic t_msg();
    logic [31:0] d;
    host_wr(8'h10, 32'hCAFE_0001);
    host_wr(8'h14, 32'h0BAD_0002);
    check("R7 imsg0 to device", imsg0, 32'hCAFE_0001);
    check("R7 imsg1 to device", imsg1, 32'h0BAD_0002);
    host_rd(8'h24, d); check("R7 istat msg bits", d, 32'h3);
    check("R9 dev irq masked", 32'(in_irq), 0);
    host_wr(8'h28, 32'h0);
    check("R9 dev irq unmasked", 32'(in_irq), 1);
    @(negedge clk); in_ack = 2'b11;
    @(negedge clk); in_ack = 2'b00;
    check("R7 ack clears irq", 32'(in_irq), 0);
    host_rd(8'h24, d); check("R7 istat cleared", d, 32'h0);
    @(negedge clk); omsg_we = 2'b01; omsg_data = 32'hCAFE_0001;
    @(negedge clk); omsg_we = 2'b00;
    host_rd(8'h18, d); check("R7 echo value", d, 32'hCAFE_0001);
    host_rd(8'h30, d); check("R7 ostat msg0", d, 32'h1);
    check("R8 irq on echo", 32'(host_irq), 1);
    host_wr(8'h30, 32'h1);
    check("R8 w1c drops irq", 32'(host_irq), 0);
    host_rd(8'h30, d); check("R8 ostat cleared", d, 32'h0);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    host_wr(8'h20, 32'h5);
    host_wr(8'h20, 32'h2);
    check("R9 doorbell OR", dbell, 32'h7);
    host_wr(8'h24, 32'hF);
    host_rd(8'h24, d); check("R9 istat doorbell, host write ignored", d, 32'h4);
    check("R9 dev irq from doorbell", 32'(in_irq), 1);
    @(negedge clk); db_clr = 32'h5;
    @(negedge clk); db_clr = 32'h0;
    check("R9 partial clear", dbell, 32'h2);
    @(negedge clk); db_clr = 32'h2;
    @(negedge clk); db_clr = 32'h0;
    host_rd(8'h24, d); check("R9 istat clear", d, 32'h0);
    check("R9 dev irq low", 32'(in_irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_free_list();
    t_post();
    t_cpl();
    t_msg();
    t_doorbell();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule